// File: doc/BRIEF.md
# Track-Addressed Instruction Delivery Unit

This unit stores program code as fixed-length tracks and hands instructions to an execution core one at a time over a valid/ready pair. The program counter is held inside the unit as a track address, a track number joined to an offset within the track. Each track also carries a header link that names the track where execution goes on when a track runs out without a jump. The core therefore sees a stream of plain instructions only. It never has to compute an address or discard anything it has fetched.

Control transfers are consumed before delivery. A single jump format covers unconditional and conditional jumps, calls and returns. A save flag copies the successor address into a link register. A return mode jumps to whatever that link register holds. The condition flag comes from the core as an input, and it must be settled before the jump reaches the head of the stream. An event request (a trap or an interrupt, with a cause number) enters a service routine in the same way as a call. The entry point is taken from a fixed vector layout indexed by the cause, and further events are masked until a return is resolved. Code and header links are written through a simple load port.

Top module: `track_fetch_unit`

## Requirements
- R1: After reset the current address and the link register are 0, event entry is enabled, and every code word and header link reads 0.
- R2: While the word at the current address is not a jump and no event is taken, out_valid is 1 and out_instr is that word. The address advances only on a cycle with out_valid and out_ready both 1, and it holds while out_ready is 0.
- R3: A handshake at the last offset of a track (offset 3 with the default 2 offset bits) moves to offset 0 of the track named by that track's header link. Any other handshake moves to offset + 1 in the same track.
- R4: A word with bit 15 set is a jump and is never delivered. In its cycle out_valid is 0 whatever out_ready is. The jump is resolved in one cycle, so the next word presented is the first one at the resolved address. The target is in bits 4:0 as {track[4:2], offset[1:0]}.
- R5: Jump mode bits 13:12 select the rule: 0 always taken, 1 taken when cond_in is 1, 2 taken when cond_in is 0. A jump that is not taken continues as the sequential successor of R3.
- R6: A taken jump with save bit 14 set loads the link register with the sequential successor of the jump's own address. A jump that is not taken leaves the link register unchanged.
- R7: Mode 3 is a return. It is always taken, its target is the current link register, and it re-enables event entry.
- R8: When irq_req is 1 and event entry is enabled, that cycle shows out_valid 0 and irq_ack 1. The link register takes the current (undelivered) address, and the next address is offset 0 of track 4 + irq_cause. This takes priority over delivery and over jump resolution.
- R9: After an event is entered, irq_req is ignored (irq_ack stays 0 and delivery goes on) until a return has been resolved.
- R10: ld_we writes ld_data to the code word at ld_addr. hdr_we writes hdr_link as the header link of track hdr_track. Both take effect at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_we | input | 1 | Code word write strobe |
| ld_addr | input | 5 | Code word address {track, offset} |
| ld_data | input | 16 | Code word to write |
| hdr_we | input | 1 | Header link write strobe |
| hdr_track | input | 3 | Track whose header link is written |
| hdr_link | input | 3 | Fall-through track to store |
| cond_in | input | 1 | Condition flag from the core |
| irq_req | input | 1 | Trap or interrupt request |
| irq_cause | input | 2 | Cause number selecting the vector |
| irq_ack | output | 1 | Event taken this cycle |
| out_valid | output | 1 | A plain instruction is offered |
| out_ready | input | 1 | Core accepts the offered instruction |
| out_instr | output | 16 | Word at the current address |
| cur_addr | output | 5 | Current track address |
| link_addr | output | 5 | Link (return) register |

## Verification
out_valid, out_instr and irq_ack are decoded combinationally from the current address and the inputs of the same cycle. So they are due in the very cycle a stimulus is applied. Address, link register and mask changes appear one clock edge later. The bench applies each vector just after a falling edge and samples 1 ns later, well before the rising edge that commits it. The next vector therefore sees the state that edge produced: a jump occupies exactly one row with out_valid low, and the row after it must show the target word.

// File: rtl/tfu_pkg.sv
package tfu_pkg;
  // Jump rule field of a jump word
  typedef enum logic [1:0] {
    JM_ALWAYS = 2'd0,
    JM_IF_SET = 2'd1,
    JM_IF_CLR = 2'd2,
    JM_RETURN = 2'd3
  } jmode_t;
endpackage

// File: rtl/tfu_store.sv
module tfu_store #(
  parameter int TRACK_BITS = 3,
  parameter int OFF_BITS   = 2,
  parameter int INSTR_W    = 16
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          ld_we,
  input  logic [TRACK_BITS+OFF_BITS-1:0] ld_addr,
  input  logic [INSTR_W-1:0]            ld_data,
  input  logic                          hdr_we,
  input  logic [TRACK_BITS-1:0]         hdr_track,
  input  logic [TRACK_BITS-1:0]         hdr_link,
  input  logic [TRACK_BITS+OFF_BITS-1:0] rd_addr,
  output logic [INSTR_W-1:0]            rd_data,
  output logic [TRACK_BITS-1:0]         rd_link
);
  localparam int ADDR_W = TRACK_BITS + OFF_BITS;
  localparam int DEPTH  = 2 ** ADDR_W;
  localparam int NTRACK = 2 ** TRACK_BITS;

  logic [INSTR_W-1:0]    words [DEPTH];
  logic [TRACK_BITS-1:0] links [NTRACK];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) words[i] <= '0;
    end else if (ld_we) begin
      words[ld_addr] <= ld_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NTRACK; i++) links[i] <= '0;
    end else if (hdr_we) begin
      links[hdr_track] <= hdr_link;
    end
  end

  assign rd_data = words[rd_addr];
  assign rd_link = links[rd_addr[ADDR_W-1:OFF_BITS]];

  // R10: a load lands in the addressed word / header at the next edge
  p_word_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ld_we |=> words[$past(ld_addr)] == $past(ld_data));
  p_hdr_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_we |=> links[$past(hdr_track)] == $past(hdr_link));
endmodule

// File: rtl/tfu_decode.sv
module tfu_decode
  import tfu_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic [3:0]        ctl_bits,   // {jump, save, mode[1:0]}
  input  logic [ADDR_W-1:0] tgt_field,
  input  logic              cond_in,
  input  logic [ADDR_W-1:0] link_in,
  output logic              is_jump,
  output logic              is_ret,
  output logic              save,
  output logic              taken,
  output logic [ADDR_W-1:0] target
);
  jmode_t mode;

  function automatic logic rule_met(jmode_t m, logic c);
    case (m)
      JM_ALWAYS: rule_met = 1'b1;
      JM_IF_SET: rule_met = c;
      JM_IF_CLR: rule_met = !c;
      default:   rule_met = 1'b1;
    endcase
  endfunction

  assign mode    = jmode_t'(ctl_bits[1:0]);
  assign is_jump = ctl_bits[3];
  assign save    = ctl_bits[2];
  assign is_ret  = is_jump && (mode == JM_RETURN);
  assign taken   = is_jump && rule_met(mode, cond_in);
  assign target  = is_ret ? link_in : tgt_field;
endmodule

// File: rtl/track_fetch_unit.sv
module track_fetch_unit #(
  parameter int TRACK_BITS = 3,
  parameter int OFF_BITS   = 2,
  parameter int INSTR_W    = 16,
  parameter int CAUSE_BITS = 2,
  parameter int VEC_BASE   = 4
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           ld_we,
  input  logic [TRACK_BITS+OFF_BITS-1:0] ld_addr,
  input  logic [INSTR_W-1:0]             ld_data,
  input  logic                           hdr_we,
  input  logic [TRACK_BITS-1:0]          hdr_track,
  input  logic [TRACK_BITS-1:0]          hdr_link,
  input  logic                           cond_in,
  input  logic                           irq_req,
  input  logic [CAUSE_BITS-1:0]          irq_cause,
  output logic                           irq_ack,
  output logic                           out_valid,
  input  logic                           out_ready,
  output logic [INSTR_W-1:0]             out_instr,
  output logic [TRACK_BITS+OFF_BITS-1:0] cur_addr,
  output logic [TRACK_BITS+OFF_BITS-1:0] link_addr
);
  localparam int ADDR_W = TRACK_BITS + OFF_BITS;
  localparam logic [OFF_BITS-1:0] OFF_LAST = '1;

  logic [ADDR_W-1:0]     pc_q, jrr_q;
  logic                  ie_q;
  logic [INSTR_W-1:0]    word;
  logic [TRACK_BITS-1:0] cur_link;
  logic                  is_jump, is_ret, save, taken;
  logic [ADDR_W-1:0]     target, seq_addr, vec_addr;
  logic                  irq_take, fire;

  // sequential successor: wrap to the header's fall-through track
  function automatic logic [ADDR_W-1:0] next_seq(logic [ADDR_W-1:0] a,
                                                 logic [TRACK_BITS-1:0] lk);
    if (a[OFF_BITS-1:0] == OFF_LAST) next_seq = {lk, {OFF_BITS{1'b0}}};
    else                             next_seq = a + ADDR_W'(1);
  endfunction

  function automatic logic [ADDR_W-1:0] vector_of(logic [CAUSE_BITS-1:0] c);
    vector_of = {TRACK_BITS'(VEC_BASE) + TRACK_BITS'(c), {OFF_BITS{1'b0}}};
  endfunction

  tfu_store #(.TRACK_BITS(TRACK_BITS), .OFF_BITS(OFF_BITS), .INSTR_W(INSTR_W)) u_store (
    .clk(clk), .rst_n(rst_n),
    .ld_we(ld_we), .ld_addr(ld_addr), .ld_data(ld_data),
    .hdr_we(hdr_we), .hdr_track(hdr_track), .hdr_link(hdr_link),
    .rd_addr(pc_q), .rd_data(word), .rd_link(cur_link)
  );

  tfu_decode #(.ADDR_W(ADDR_W)) u_dec (
    .ctl_bits(word[INSTR_W-1 -: 4]), .tgt_field(word[ADDR_W-1:0]),
    .cond_in(cond_in), .link_in(jrr_q),
    .is_jump(is_jump), .is_ret(is_ret), .save(save), .taken(taken), .target(target)
  );

  assign seq_addr  = next_seq(pc_q, cur_link);
  assign vec_addr  = vector_of(irq_cause);
  assign irq_take  = irq_req && ie_q;
  assign out_valid = !is_jump && !irq_take;
  assign fire      = out_valid && out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc_q  <= '0;
      jrr_q <= '0;
      ie_q  <= 1'b1;
    end else if (irq_take) begin
      pc_q  <= vec_addr;
      jrr_q <= pc_q;
      ie_q  <= 1'b0;
    end else if (is_jump) begin
      pc_q <= taken ? target : seq_addr;
      if (taken && save) jrr_q <= seq_addr;
      if (is_ret) ie_q <= 1'b1;
    end else if (fire) begin
      pc_q <= seq_addr;
    end
  end

  assign irq_ack   = irq_take;
  assign out_instr = word;
  assign cur_addr  = pc_q;
  assign link_addr = jrr_q;

  // R2: no handshake and no event -> address holds
  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> $stable(cur_addr));
  // R3: end-of-track handshake follows the header link
  p_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && cur_addr[OFF_BITS-1:0] == OFF_LAST)
      |=> cur_addr == {$past(cur_link), {OFF_BITS{1'b0}}});
  // R4: a jump word is never offered to the core
  p_no_jump_out_r4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !out_instr[INSTR_W-1]);
  // R5: an untaken jump continues sequentially
  p_not_taken_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (is_jump && !taken && !irq_take) |=> (cur_addr == $past(seq_addr)) && $stable(link_addr));
  // R6: taken save-jump records the successor
  p_save_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (is_jump && taken && save && !irq_take) |=> link_addr == $past(seq_addr));
  // R7: return goes to the old link and unmasks events
  p_return_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (is_ret && !irq_take) |=> (cur_addr == $past(link_addr)) && ie_q);
  // R8: event entry vectors by cause and saves the undelivered address
  p_irq_entry_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack |=> (cur_addr == {TRACK_BITS'(VEC_BASE) + TRACK_BITS'($past(irq_cause)),
                              {OFF_BITS{1'b0}}}) && (link_addr == $past(cur_addr)));
  // R9: no second entry directly after one
  p_irq_mask_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack |=> !irq_ack);
endmodule

// File: tb/track_fetch_unit_bench.sv
module track_fetch_unit_bench;
  logic clk = 1'b0;
  logic rst_n;
  logic ld_we, hdr_we, cond_in, irq_req, out_ready;
  logic [4:0]  ld_addr;
  logic [15:0] ld_data;
  logic [2:0]  hdr_track, hdr_link;
  logic [1:0]  irq_cause;
  logic        irq_ack, out_valid;
  logic [15:0] out_instr;
  logic [4:0]  cur_addr, link_addr;

  int n_tests = 0;
  int n_fail  = 0;
  int cyc     = 0;

  always #4 clk = ~clk;

  track_fetch_unit u_track_fetch_unit (
    .clk(clk), .rst_n(rst_n),
    .ld_we(ld_we), .ld_addr(ld_addr), .ld_data(ld_data),
    .hdr_we(hdr_we), .hdr_track(hdr_track), .hdr_link(hdr_link),
    .cond_in(cond_in), .irq_req(irq_req), .irq_cause(irq_cause), .irq_ack(irq_ack),
    .out_valid(out_valid), .out_ready(out_ready), .out_instr(out_instr),
    .cur_addr(cur_addr), .link_addr(link_addr)
  );

  // plain word tagged with its address; jump = {1, save, mode, 7'b0, target}
  function automatic logic [15:0] plain(int a);
    return 16'h0100 + 16'(a);
  endfunction
  function automatic logic [15:0] jmp(bit s, int m, int t);
    return {1'b1, s, 2'(m), 7'd0, 5'(t)};
  endfunction

  // {ready, cond, irq, cause[1:0], exp_valid, exp_ack, exp_instr[15:0], exp_addr[4:0], exp_link[4:0]}
  localparam int NV = 21;
  localparam logic [32:0] VEC [NV] = '{
    {1'b1,1'b0,1'b0,2'd0, 1'b1,1'b0, 16'h0100, 5'd0,  5'd0 },  // R2 first word
    {1'b0,1'b0,1'b0,2'd0, 1'b1,1'b0, 16'h0101, 5'd1,  5'd0 },  // R2 stall
    {1'b1,1'b0,1'b0,2'd0, 1'b1,1'b0, 16'h0101, 5'd1,  5'd0 },  // R2 held word
    {1'b1,1'b0,1'b0,2'd0, 1'b1,1'b0, 16'h0102, 5'd2,  5'd0 },  // R3 in-track step
    {1'b1,1'b0,1'b0,2'd0, 1'b1,1'b0, 16'h0103, 5'd3,  5'd0 },  // R3 last offset
    {1'b1,1'b0,1'b0,2'd0, 1'b1,1'b0, 16'h0104, 5'd4,  5'd0 },  // R3 wrapped via header
    {1'b0,1'b0,1'b0,2'd0, 1'b0,1'b0, 16'hC008, 5'd5,  5'd0 },  // R4 call, ready low
    {1'b1,1'b0,1'b0,2'd0, 1'b1,1'b0, 16'h0108, 5'd8,  5'd6 },  // R4 R6 target, link saved
    {1'b1,1'b0,1'b0,2'd0, 1'b0,1'b0, 16'hB000, 5'd9,  5'd6 },  // R7 return
    {1'b1,1'b0,1'b0,2'd0, 1'b1,1'b0, 16'h0106, 5'd6,  5'd6 },  // R7 back after call
    {1'b1,1'b0,1'b0,2'd0, 1'b0,1'b0, 16'hD00C, 5'd7,  5'd6 },  // R5 mode1 cond0 untaken
    {1'b1,1'b0,1'b0,2'd0, 1'b1,1'b0, 16'h010C, 5'd12, 5'd6 },  // R5 R6 sequential, link kept
    {1'b1,1'b0,1'b0,2'd0, 1'b0,1'b0, 16'hA007, 5'd13, 5'd6 },  // R5 mode2 cond0 taken
    {1'b1,1'b1,1'b0,2'd0, 1'b0,1'b0, 16'hD00C, 5'd7,  5'd6 },  // R5 mode1 cond1 taken
    {1'b1,1'b0,1'b1,2'd1, 1'b0,1'b1, 16'h010C, 5'd12, 5'd12},  // R8 entry, cause 1
    {1'b1,1'b0,1'b1,2'd1, 1'b1,1'b0, 16'h0114, 5'd20, 5'd12},  // R9 masked, vector word
    {1'b1,1'b0,1'b1,2'd1, 1'b0,1'b0, 16'hB000, 5'd21, 5'd12},  // R9 R7 return while masked
    {1'b1,1'b0,1'b1,2'd0, 1'b0,1'b1, 16'h010C, 5'd12, 5'd12},  // R8 R7 unmasked, cause 0
    {1'b1,1'b0,1'b0,2'd0, 1'b1,1'b0, 16'h0110, 5'd16, 5'd12},  // R8 vector track 4
    {1'b1,1'b0,1'b0,2'd0, 1'b0,1'b0, 16'hB000, 5'd17, 5'd12},  // R7 service return
    {1'b1,1'b0,1'b0,2'd0, 1'b1,1'b0, 16'h010C, 5'd12, 5'd12}   // R7 resumed
  };

  task automatic check(string req, logic ev, logic eack, logic [15:0] ei,
                       logic [4:0] ea, logic [4:0] el);
    n_tests++;
    if (out_valid !== ev || irq_ack !== eack || out_instr !== ei ||
        cur_addr !== ea || link_addr !== el) begin
      n_fail++;
      $display("FAIL %s: got v=%b ack=%b instr=%h addr=%0d link=%0d, expected v=%b ack=%b instr=%h addr=%0d link=%0d",
               req, out_valid, irq_ack, out_instr, cur_addr, link_addr,
               ev, eack, ei, ea, el);
    end
  endtask

  task automatic load_word(int a, logic [15:0] d);
    @(negedge clk);
    ld_we = 1'b1; ld_addr = 5'(a); ld_data = d;
    @(negedge clk);
    ld_we = 1'b0;
  endtask

  task automatic load_hdr(int t, int l);
    @(negedge clk);
    hdr_we = 1'b1; hdr_track = 3'(t); hdr_link = 3'(l);
    @(negedge clk);
    hdr_we = 1'b0;
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: got cycle %0d, expected completion", cyc);
      finish_run();
    end
  end

  initial begin
    rst_n = 1'b0; ld_we = 1'b0; hdr_we = 1'b0; cond_in = 1'b0;
    irq_req = 1'b0; irq_cause = '0; out_ready = 1'b0;
    ld_addr = '0; ld_data = '0; hdr_track = '0; hdr_link = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 R10: reset state, cleared storage presents word 0 at address 0
    check("R1", 1'b1, 1'b0, 16'h0000, 5'd0, 5'd0);

    // program (ready held low, address stays 0)
    foreach (VEC[k]) begin end
    load_word(0, plain(0));  load_word(1, plain(1));
    load_word(2, plain(2));  load_word(3, plain(3));
    load_word(4, plain(4));  load_word(5, jmp(1'b1, 0, 8));
    load_word(6, plain(6));  load_word(7, jmp(1'b1, 1, 12));
    load_word(8, plain(8));  load_word(9, jmp(1'b0, 3, 0));
    load_word(12, plain(12)); load_word(13, jmp(1'b0, 2, 7));
    load_word(16, plain(16)); load_word(17, jmp(1'b0, 3, 0));
    load_word(20, plain(20)); load_word(21, jmp(1'b0, 3, 0));
    load_hdr(0, 1);
    load_hdr(1, 3);
    #1;
    // R10: load visible at the port, address still 0
    check("R10", 1'b1, 1'b0, 16'h0100, 5'd0, 5'd0);

    // vector walk: drive after falling edge, sample 1 ns later
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      {out_ready, cond_in, irq_req, irq_cause} = VEC[i][32:28];
      #1;
      check($sformatf("vector row %0d", i), VEC[i][27], VEC[i][26],
            VEC[i][25:10], VEC[i][9:5], VEC[i][4:0]);
    end

    // R2: long stall holds address and word
    @(negedge clk);
    out_ready = 1'b0; irq_req = 1'b0; cond_in = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    check("R2", 1'b1, 1'b0, 16'h010C, 5'd12, 5'd12);

    // R8: entry taken even with ready low, cause 3 -> track 7
    @(negedge clk);
    irq_req = 1'b1; irq_cause = 2'd3;
    #1;
    check("R8", 1'b0, 1'b1, 16'h010C, 5'd12, 5'd12);
    @(negedge clk);
    irq_req = 1'b0;
    #1;
    check("R8", 1'b1, 1'b0, 16'h0000, 5'd28, 5'd12);

    // R9: still masked, request ignored, stall holds
    @(negedge clk);
    irq_req = 1'b1; irq_cause = 2'd0;
    #1;
    check("R9", 1'b1, 1'b0, 16'h0000, 5'd28, 5'd12);
    @(negedge clk);
    irq_req = 1'b0;

    // R1 R10: second reset clears address, link and storage
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    out_ready = 1'b1;
    #1;
    check("R1", 1'b1, 1'b0, 16'h0000, 5'd0, 5'd0);
    // R1: header links cleared -> end of track 0 returns to track 0
    repeat (4) @(negedge clk);
    #1;
    check("R1", 1'b1, 1'b0, 16'h0000, 5'd0, 5'd0);

    finish_run();
  end
endmodule